// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only, three-wire configuration port. A host drives a serial clock, a data line and a latch line. While the latch line is low, each rising edge of the serial clock shifts one data bit into an eight-bit shift register, most significant bit first. When the latch line rises, the most recent eight bits form a command byte. The two low bits of the byte pick one of four six-bit registers, and the upper six bits become that register's new contents.

The three serial lines are sampled by the block's own system clock. A parameter sets the number of synchronizer stages; zero stages means the lines already belong to the system clock domain.

The registers are decoded into ready-to-use fields for the rest of the chip:
- conversion mode and offset-calibration enable for two channels;
- threshold-detector time and level;
- pre-trigger mode.

An asynchronous active-high reset returns every register to its default value.

Top module: `serial_cfg_port`

## Requirements
- R1: The data line is sampled on rising edges of the serial clock, and the first bit shifted in ends up as bit 7 of the command byte (MSB first).
- R2: Serial clock rising edges that arrive while the latch line is high shift nothing. A later latch pulse with no clocks in between recommits the byte shifted before those edges.
- R3: A rising edge of the latch line commits the last eight bits shifted. Any bits shifted before those eight have no effect.
- R4: Byte bits 1:0 select the target register. 00 is channel 1 mode and calibration, 01 is channel 2 mode and calibration, 10 is the threshold detector and 11 is the pre-trigger. A commit changes no other register.
- R5: For registers 00 and 01, byte bits 7:4 hold the conversion code and byte bit 3 enables offset calibration (1 = on). The code is reported as a 3-bit mode number: 0101 gives 1, 0011 gives 2, 1110 gives 3, 1100 gives 4 and 1010 gives 5.
- R6: Any other conversion code reports mode 3. Reserved bits are stored but never change any output: byte bit 2 of registers 00 and 01, and byte bits 5:2 of register 11.
- R7: For register 10, byte bits 7:6 appear unchanged on `thr_time` and byte bits 5:2 appear unchanged on `thr_level`.
- R8: For register 11, byte bits 7:6 select the pre-trigger mode as a 2-bit number: 00 gives 0, 01 gives 1, and 10 or 11 give 2.
- R9: While `rst` is high, with no clock edge needed, every output shows its default:
  - both conversion modes 3;
  - both calibration enables 0;
  - `thr_time` 00;
  - `thr_level` 1001;
  - pre-trigger mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Asynchronous active-high reset to defaults |
| cfg_sclk | input | 1 | Serial clock; data is taken on its rising edge |
| cfg_sdat | input | 1 | Serial data, MSB first |
| cfg_latch | input | 1 | Low while shifting; rising edge commits the byte |
| ch1_conv_mode | output | 3 | Channel 1 conversion mode number (1 to 5) |
| ch1_offset_cal | output | 1 | Channel 1 offset calibration enable |
| ch2_conv_mode | output | 3 | Channel 2 conversion mode number (1 to 5) |
| ch2_offset_cal | output | 1 | Channel 2 offset calibration enable |
| thr_time | output | 2 | Threshold detector time select |
| thr_level | output | 4 | Threshold detector level code |
| pretrig_mode | output | 2 | Pre-trigger mode number (0 to 2) |

## Verification
The bench builds the port with three synchronizer stages, one more than the default. This lengthens the path from a serial edge to a commit and shows that the bench's settling waits do not rely on a fixed latency. The payload and address widths keep their defaults of six and two bits, the only values the field decode accepts. With these values every conversion code, both ends of each field, and all four addresses can be reached through the serial lines. The same holds for over-long frames and clock edges sent while the latch line is high.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int unsigned CFG_PAY_W  = 6;
   localparam int unsigned CFG_ADDR_W = 2;
   localparam int unsigned CFG_NREG   = 1 << CFG_ADDR_W;

   // Register defaults, index 3 down to 0.
   // reg0/reg1: conversion code 1110 (mode 3), calibration off, reserved 0
   // reg2     : time 00, level 1001
   // reg3     : pre-trigger 00, reserved 0000
   localparam logic [CFG_NREG-1:0][CFG_PAY_W-1:0] CFG_DEFAULTS =
      {6'b000000, 6'b001001, 6'b111000, 6'b111000};

   function automatic logic [2:0] conv_mode_of(input logic [3:0] code);
      case (code)
         4'b0101: return 3'd1;
         4'b0011: return 3'd2;
         4'b1110: return 3'd3;
         4'b1100: return 3'd4;
         4'b1010: return 3'd5;
         default: return 3'd3;
      endcase
   endfunction

   function automatic logic [1:0] pretrig_of(input logic [1:0] sel);
      if (sel[1])      return 2'd2;
      else if (sel[0]) return 2'd1;
      else             return 2'd0;
   endfunction
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic lvl,
   output logic rise
);
   logic prev;

   generate
      if (STAGES == 1) begin : g_bad
         $error("cfg_line_sync: STAGES must be 0 or at least 2");
      end
      if (STAGES == 0) begin : g_bypass
         assign lvl = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain <= {STAGES{RST_VAL}};
            else     chain <= {chain[STAGES-2:0], d};
         end
         assign lvl = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) prev <= RST_VAL;
      else     prev <= lvl;
   end

   assign rise = lvl & ~prev;

   // a rising-edge pulse never lasts two cycles
   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise); // R1
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 2) begin : g_bad
         $error("cfg_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst)           q <= '0;
      else if (shift_en) q <= {q[WIDTH-2:0], din};
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(q)); // R2
   AST_NEWEST_AT_LSB: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> q[0] == $past(din)); // R1
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
   parameter int unsigned PAY_W  = 6,
   parameter int unsigned ADDR_W = 2,
   localparam int unsigned NREG  = 1 << ADDR_W,
   parameter logic [NREG-1:0][PAY_W-1:0] DEFAULTS = '0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [PAY_W-1:0]           wr_data,
   output logic [NREG-1:0][PAY_W-1:0] q
);
   logic [NREG-1:0] wr_sel;

   generate
      if (PAY_W == 0 || ADDR_W == 0) begin : g_bad
         $error("cfg_reg_bank: PAY_W and ADDR_W must be non-zero");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));

         always_ff @(posedge clk or posedge rst) begin
            if (rst)            q[i] <= DEFAULTS[i];
            else if (wr_sel[i]) q[i] <= wr_data;
         end

         AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(i)) |=> q[i] == $past(wr_data)); // R3
         AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_addr == ADDR_W'(i)) |=> $stable(q[i])); // R4
      end
   endgenerate

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_sel)); // R4
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
   import cfg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PAY_W       = CFG_PAY_W,
   parameter int unsigned ADDR_W      = CFG_ADDR_W
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cfg_sclk,
   input  logic       cfg_sdat,
   input  logic       cfg_latch,
   output logic [2:0] ch1_conv_mode,
   output logic       ch1_offset_cal,
   output logic [2:0] ch2_conv_mode,
   output logic       ch2_offset_cal,
   output logic [1:0] thr_time,
   output logic [3:0] thr_level,
   output logic [1:0] pretrig_mode
);
   localparam int unsigned BYTE_W = PAY_W + ADDR_W;
   localparam int unsigned NREG   = 1 << ADDR_W;

   generate
      if (PAY_W != CFG_PAY_W || ADDR_W != CFG_ADDR_W) begin : g_bad
         $error("serial_cfg_port: field decode needs a 6-bit payload and 2-bit address");
      end
   endgenerate

   logic sclk_lvl, sclk_rise;
   logic dat_lvl, dat_rise;
   logic lat_lvl, lat_rise;
   logic shift_en;
   logic [BYTE_W-1:0]          sh_byte;
   logic [NREG-1:0][PAY_W-1:0] regs;

   cfg_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst(rst), .d(cfg_sclk), .lvl(sclk_lvl), .rise(sclk_rise));
   cfg_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst(rst), .d(cfg_sdat), .lvl(dat_lvl), .rise(dat_rise));
   // latch idles high so that reset release never looks like a commit
   cfg_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lat (
      .clk(clk), .rst(rst), .d(cfg_latch), .lvl(lat_lvl), .rise(lat_rise));

   assign shift_en = sclk_rise & ~lat_lvl;

   cfg_shift_reg #(.WIDTH(BYTE_W)) u_shift (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(dat_lvl), .q(sh_byte));

   cfg_reg_bank #(.PAY_W(PAY_W), .ADDR_W(ADDR_W), .DEFAULTS(CFG_DEFAULTS)) u_bank (
      .clk(clk), .rst(rst), .wr_en(lat_rise),
      .wr_addr(sh_byte[ADDR_W-1:0]), .wr_data(sh_byte[BYTE_W-1:ADDR_W]),
      .q(regs));

   // payload bit p maps to byte bit p+2; bit 0 of regs 0, 1 and bits 3:0 of reg 3 are reserved
   always_comb begin
      ch1_conv_mode  = conv_mode_of(regs[0][5:2]);
      ch1_offset_cal = regs[0][1];
      ch2_conv_mode  = conv_mode_of(regs[1][5:2]);
      ch2_offset_cal = regs[1][1];
      thr_time       = regs[2][5:4];
      thr_level      = regs[2][3:0];
      pretrig_mode   = pretrig_of(regs[3][5:4]);
   end

   AST_CAL_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
      (lat_rise && sh_byte[1:0] == 2'b00) |=> ch1_offset_cal == $past(sh_byte[3])); // R5
   AST_LEVEL_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
      (lat_rise && sh_byte[1:0] == 2'b10) |=> thr_level == $past(sh_byte[5:2])); // R7
   AST_MODE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      ch1_conv_mode != 3'd0 && ch1_conv_mode <= 3'd5 &&
      ch2_conv_mode != 3'd0 && ch2_conv_mode <= 3'd5); // R6
   AST_PRETRIG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      pretrig_mode != 2'd3); // R8
   AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> ch1_conv_mode == 3'd3 && ch2_conv_mode == 3'd3 &&
      !ch1_offset_cal && !ch2_offset_cal && thr_time == 2'b00 &&
      thr_level == 4'b1001 && pretrig_mode == 2'd0); // R9
endmodule

// File: tb/tb_serial_cfg_port.sv
`timescale 1ns/1ps
module tb_serial_cfg_port;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_sclk = 1'b0, cfg_sdat = 1'b0, cfg_latch = 1'b1;
   logic [2:0] ch1_conv_mode, ch2_conv_mode;
   logic       ch1_offset_cal, ch2_offset_cal;
   logic [1:0] thr_time, pretrig_mode;
   logic [3:0] thr_level;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serial_cfg_port #(.SYNC_STAGES(3)) dut (
      .clk(clk), .rst(rst), .cfg_sclk(cfg_sclk), .cfg_sdat(cfg_sdat),
      .cfg_latch(cfg_latch), .ch1_conv_mode(ch1_conv_mode),
      .ch1_offset_cal(ch1_offset_cal), .ch2_conv_mode(ch2_conv_mode),
      .ch2_offset_cal(ch2_offset_cal), .thr_time(thr_time),
      .thr_level(thr_level), .pretrig_mode(pretrig_mode));

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clock_bit(input logic b);
      cfg_sdat = b;
      wait_cyc(4);
      cfg_sclk = 1'b1;
      wait_cyc(4);
      cfg_sclk = 1'b0;
      wait_cyc(4);
   endtask

   // shifts the low n bits of v, MSB first, inside one latch-low window
   task automatic send_frame(input logic [15:0] v, input int n);
      cfg_latch = 1'b0;
      wait_cyc(4);
      for (int i = n - 1; i >= 0; i--) clock_bit(v[i]);
      cfg_latch = 1'b1;
      wait_cyc(12);
   endtask

   task automatic send_byte(input logic [7:0] b);
      send_frame({8'h00, b}, 8);
   endtask

   task automatic check_defaults(input string tag);
      check({tag, " ch1 mode"}, ch1_conv_mode, 3);
      check({tag, " ch2 mode"}, ch2_conv_mode, 3);
      check({tag, " ch1 cal"},  ch1_offset_cal, 0);
      check({tag, " ch2 cal"},  ch2_offset_cal, 0);
      check({tag, " thr time"}, thr_time, 0);
      check({tag, " thr level"}, thr_level, 9);
      check({tag, " pretrig"},  pretrig_mode, 0);
   endtask

   task automatic t_reset_state;
      check_defaults("R9 reset");
   endtask

   task automatic t_conv_codes;
      logic [3:0] codes [5] = '{4'b0101, 4'b0011, 4'b1110, 4'b1100, 4'b1010};
      for (int k = 0; k < 5; k++) begin
         send_byte({codes[k], 1'b1, 1'b0, 2'b00});
         check("R5 R1 ch1 code", ch1_conv_mode, k + 1);
         check("R5 ch1 cal on", ch1_offset_cal, 1);
      end
      send_byte({4'b0011, 1'b0, 1'b0, 2'b01});
      check("R5 ch2 code 0011", ch2_conv_mode, 2);
      check("R5 ch2 cal off", ch2_offset_cal, 0);
      check("R4 ch1 untouched", ch1_conv_mode, 5);
      check("R4 ch1 cal untouched", ch1_offset_cal, 1);
   endtask

   task automatic t_bad_and_reserved;
      send_byte({4'b0000, 1'b0, 1'b0, 2'b00});
      check("R6 code 0000", ch1_conv_mode, 3);
      send_byte({4'b1111, 1'b0, 1'b0, 2'b01});
      check("R6 code 1111", ch2_conv_mode, 3);
      send_byte({4'b1100, 1'b0, 1'b1, 2'b01});
      check("R6 reserved bit ch2 mode", ch2_conv_mode, 4);
      check("R6 reserved bit ch2 cal", ch2_offset_cal, 0);
   endtask

   task automatic t_threshold;
      send_byte({2'b10, 4'b0110, 2'b10});
      check("R7 time", thr_time, 2);
      check("R7 level", thr_level, 6);
      send_byte({2'b11, 4'b1111, 2'b10});
      check("R7 time max", thr_time, 3);
      check("R7 level max", thr_level, 15);
      check("R4 ch2 untouched", ch2_conv_mode, 4);
   endtask

   task automatic t_pretrig;
      send_byte({2'b01, 4'b0000, 2'b11});
      check("R8 sel 01", pretrig_mode, 1);
      send_byte({2'b10, 4'b0000, 2'b11});
      check("R8 sel 10", pretrig_mode, 2);
      send_byte({2'b11, 4'b0000, 2'b11});
      check("R8 sel 11", pretrig_mode, 2);
      send_byte({2'b00, 4'b1111, 2'b11});
      check("R8 R6 sel 00 reserved set", pretrig_mode, 0);
      check("R4 thr level untouched", thr_level, 15);
   endtask

   task automatic t_extra_bits;
      // 12 bits: 1111 then level write {00,0011,10}
      send_frame({4'h0, 4'b1111, 2'b00, 4'b0011, 2'b10}, 12);
      check("R3 extra bits time", thr_time, 0);
      check("R3 extra bits level", thr_level, 3);
   endtask

   task automatic t_latch_high_ignored;
      send_byte({2'b01, 4'b0000, 2'b11});
      check("R2 setup pretrig", pretrig_mode, 1);
      // edges while latch is high: would form {10,0000,11}
      for (int i = 7; i >= 0; i--) clock_bit(8'b1000_0011 >> i);
      check("R2 no commit without latch", pretrig_mode, 1);
      cfg_latch = 1'b0;
      wait_cyc(6);
      cfg_latch = 1'b1;
      wait_cyc(12);
      check("R2 recommit keeps old byte", pretrig_mode, 1);
   endtask

   task automatic t_async_reset;
      send_byte({4'b1010, 1'b1, 1'b0, 2'b01});
      check("R5 ch2 before reset", ch2_conv_mode, 5);
      @(posedge clk);
      #1.2 rst = 1'b1;
      #0.5;
      check_defaults("R9 async");
      wait_cyc(3);
      rst = 1'b0;
      wait_cyc(4);
      check_defaults("R9 after release");
   endtask

   task automatic report;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      wait_cyc(5);
      rst = 1'b0;
      wait_cyc(5);
      t_reset_state();
      t_conv_codes();
      t_bad_and_reserved();
      t_threshold();
      t_pretrig();
      t_extra_bits();
      t_latch_high_ignored();
      t_async_reset();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end
endmodule